// File: doc/BRIEF.md
# Standby DRAM Refresh Controller

This block issues DRAM refresh strobe requests from one of two timebases. While system power is good, it divides the system clock by a fixed count so that a refresh falls every 15.6 µs. When power-good drops and standby refresh is allowed, the block moves to a 32 kHz timebase by itself and issues one refresh per rising edge of that slow clock. This keeps DRAM contents while the rest of the system is down. The block clock keeps running in standby. The slow clock is brought into that domain through a synchronizer.

A small configuration register holds three fields: a standby permit, a CAS-before-RAS select and a hold length. In CAS-before-RAS sequencing the DRAM picks its own row, so no address is driven. In RAS-only sequencing the block drives a row address from an internal counter, which steps once per refresh. Standby refresh always uses CAS-before-RAS. A timebase change is taken only while the sequencer is idle, so a strobe sequence in flight always completes.

The sequencer has five states:
- `ST_IDLE`
- `ST_CBR_LEAD` (CAS alone)
- `ST_CBR_BOTH` (CAS and RAS)
- `ST_CBR_TAIL` (RAS alone)
- `ST_ROR_HOLD` (RAS with the row address)

Its transitions are:
- IDLE→CBR_LEAD on a pending request with CAS-before-RAS in force.
- IDLE→ROR_HOLD on a pending request otherwise.
- CBR_LEAD→CBR_BOTH always.
- CBR_BOTH→CBR_TAIL when the hold count is reached.
- CBR_TAIL→IDLE always.
- ROR_HOLD→IDLE when the hold count is reached, stepping the row.

Top module: `rfsh_standby_ctrl`

## Requirements
- R1: With `pwr_good` high, refresh sequences start exactly every NORM_DIV (default 223) clocks.
- R2: A write with `cfg_wr` high loads `cfg_wdata` into the configuration register on that clock edge. Bit 0 permits standby refresh. Bit 1 selects CAS-before-RAS. Bits [2+HOLD_W-1:2] hold a field h that sets the hold length, which is h+1 clocks.
- R3: With `pwr_good` low and bit 0 set, one refresh sequence starts per rising edge of `slow_clk`, so starts are spaced by the slow clock period.
- R4: With `pwr_good` low and bit 0 clear, no new sequence starts and `ras_req`, `cas_req` and `row_valid` stay low once any sequence in flight has completed.
- R5: With bit 1 set and `pwr_good` high, every refresh is CAS-before-RAS and `row_valid` stays low.
- R6: Refresh in standby is always CAS-before-RAS, whatever bit 1 holds, and drives no row address.
- R7: A CAS-before-RAS sequence proceeds in this order:
  - `cas_req` rises alone for one clock.
  - Both strobes are then high for h+1 clocks.
  - `cas_req` then falls while `ras_req` stays high for one more clock.
- R8: A RAS-only sequence holds `ras_req` and `row_valid` high for h+1 clocks, with `cas_req` low. `row_addr` carries the row counter while `row_valid` is high and is zero otherwise.
- R9: The row counter starts at zero after reset, advances by one after each RAS-only sequence and wraps from 2^ROW_W−1 to 0.
- R10: The timebase and the sequence type change only while the sequencer is idle. A power-good drop during a RAS-only sequence leaves that sequence at full length.
- R11: A request that arrives while a sequence is running is kept. The next sequence then begins with exactly one idle clock after `ras_req` falls.
- R12: After reset all strobes, `row_valid` and `row_addr` are low, the row counter is zero and the configuration is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock (system clock timebase) |
| rst_n | input | 1 | asynchronous active-low reset |
| pwr_good | input | 1 | system power good level |
| slow_clk | input | 1 | 32 kHz standby clock, asynchronous |
| cfg_wr | input | 1 | configuration register write strobe |
| cfg_wdata | input | 2+HOLD_W | configuration value (permit, select, hold field) |
| ras_req | output | 1 | RAS strobe request |
| cas_req | output | 1 | CAS strobe request |
| row_valid | output | 1 | row address is being driven |
| row_addr | output | ROW_W | refresh row in RAS-only mode, zero otherwise |

## Verification
A new refresh request can arrive in the same clock in which the sequencer consumes the previous one or is still running it. The controller must keep the new request and not drop it. This is provoked in standby by toggling the slow clock faster than a long CAS-before-RAS sequence lasts, which keeps a request always pending. It is judged by the behavioural reference model, compared every clock, and by a check that exactly one idle clock separates consecutive sequences. A power-good drop during a RAS-only sequence is the other collision. There the full-length `row_valid` pulse and the later switch to CAS-before-RAS are judged the same way.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CBR_LEAD,
        ST_CBR_BOTH,
        ST_CBR_TAIL,
        ST_ROR_HOLD
    } rfsh_state_t;

    typedef enum logic [1:0] {
        TB_OFF,
        TB_NORM,
        TB_STBY
    } tb_mode_t;

endpackage

// File: rtl/rfsh_timebase.sv
module rfsh_timebase
    import rfsh_pkg::*;
#(
    parameter int NORM_DIV = 223
) (
    input  logic     clk,
    input  logic     rst_n,
    input  tb_mode_t mode_q,
    input  logic     slow_clk,
    output logic     tick
);
    logic [2:0] sync_q;
    logic       slow_rise;
    logic       norm_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], slow_clk};
        end
    end

    assign slow_rise = sync_q[1] & ~sync_q[2];

    generate
        if (NORM_DIV < 2) begin : g_div_one
            assign norm_tick = (mode_q == TB_NORM);
        end else begin : g_div_cnt
            localparam int CNT_W = $clog2(NORM_DIV);
            localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NORM_DIV - 1);
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (mode_q != TB_NORM || cnt_q == CNT_LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign norm_tick = (mode_q == TB_NORM) && (cnt_q == CNT_LAST);
        end
    endgenerate

    assign tick = norm_tick || ((mode_q == TB_STBY) && slow_rise);

endmodule

// File: rtl/rfsh_seq_fsm.sv
module rfsh_seq_fsm
    import rfsh_pkg::*;
#(
    parameter int HOLD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  tb_mode_t          mode_now,
    input  logic              cfg_cbr,
    input  logic [HOLD_W-1:0] cfg_hold,
    output tb_mode_t          mode_q,
    output rfsh_state_t       state,
    output logic              ras,
    output logic              cas,
    output logic              row_drive,
    output logic              seq_done
);
    rfsh_state_t       state_nx;
    logic              pend_q;
    logic              start;
    logic              use_cbr;
    logic [HOLD_W-1:0] hold_q;
    logic [HOLD_W-1:0] hc_q;
    logic              hold_phase;
    logic              hold_end;

    assign start      = (state == ST_IDLE) && pend_q && (mode_q != TB_OFF);
    assign use_cbr    = cfg_cbr || (mode_q == TB_STBY);
    assign hold_phase = (state == ST_CBR_BOTH) || (state == ST_ROR_HOLD);
    assign hold_end   = hold_phase && (hc_q == hold_q);
    assign seq_done   = (state == ST_ROR_HOLD) && (hc_q == hold_q);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start) state_nx = use_cbr ? ST_CBR_LEAD : ST_ROR_HOLD;
            ST_CBR_LEAD: state_nx = ST_CBR_BOTH;
            ST_CBR_BOTH: if (hold_end) state_nx = ST_CBR_TAIL;
            ST_CBR_TAIL: state_nx = ST_IDLE;
            ST_ROR_HOLD: if (hold_end) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            mode_q <= TB_OFF;
            pend_q <= 1'b0;
            hold_q <= '0;
            hc_q   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE) begin
                mode_q <= mode_now;
            end
            if (mode_q == TB_OFF) begin
                pend_q <= 1'b0;
            end else if (tick) begin
                pend_q <= 1'b1;
            end else if (start) begin
                pend_q <= 1'b0;
            end
            if (start) begin
                hold_q <= cfg_hold;
            end
            hc_q <= (hold_phase && !hold_end) ? hc_q + 1'b1 : '0;
        end
    end

    always_comb begin
        ras       = 1'b0;
        cas       = 1'b0;
        row_drive = 1'b0;
        unique case (state)
            ST_IDLE:     ;
            ST_CBR_LEAD: cas = 1'b1;
            ST_CBR_BOTH: begin cas = 1'b1; ras = 1'b1; end
            ST_CBR_TAIL: ras = 1'b1;
            ST_ROR_HOLD: begin ras = 1'b1; row_drive = 1'b1; end
            default:     ;
        endcase
    end

endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [ROW_W-1:0] row
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row <= '0;
        end else if (advance) begin
            row <= row + 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_standby_ctrl.sv
module rfsh_standby_ctrl
    import rfsh_pkg::*;
#(
    parameter int NORM_DIV = 223,
    parameter int ROW_W    = 9,
    parameter int HOLD_W   = 3,
    localparam int CFG_W   = 2 + HOLD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good,
    input  logic             slow_clk,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             ras_req,
    output logic             cas_req,
    output logic             row_valid,
    output logic [ROW_W-1:0] row_addr
);
    logic [CFG_W-1:0] cfg_q;
    tb_mode_t         mode_now;
    tb_mode_t         mode_q;
    rfsh_state_t      state;
    logic             tick;
    logic             seq_done;
    logic [ROW_W-1:0] row_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q <= cfg_wdata;
        end
    end

    always_comb begin
        if (pwr_good)      mode_now = TB_NORM;
        else if (cfg_q[0]) mode_now = TB_STBY;
        else               mode_now = TB_OFF;
    end

    rfsh_timebase #(.NORM_DIV(NORM_DIV)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_q   (mode_q),
        .slow_clk (slow_clk),
        .tick     (tick)
    );

    rfsh_seq_fsm #(.HOLD_W(HOLD_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode_now  (mode_now),
        .cfg_cbr   (cfg_q[1]),
        .cfg_hold  (cfg_q[2 +: HOLD_W]),
        .mode_q    (mode_q),
        .state     (state),
        .ras       (ras_req),
        .cas       (cas_req),
        .row_drive (row_valid),
        .seq_done  (seq_done)
    );

    rfsh_row_ctr #(.ROW_W(ROW_W)) u_row (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (seq_done),
        .row     (row_cnt)
    );

    assign row_addr = row_valid ? row_cnt : '0;

endmodule

// File: rtl/rfsh_standby_ctrl_chk.sv
module rfsh_standby_ctrl_chk
    import rfsh_pkg::*;
#(
    parameter int ROW_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras,
    input logic             cas,
    input logic             row_drive,
    input logic [ROW_W-1:0] row,
    input rfsh_state_t      state,
    input tb_mode_t         mode_q
);
    assert_cas_leads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras) && cas) |-> $past(cas));

    assert_cas_drops_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas) |-> ras);

    assert_row_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(row_drive) |-> (row == ROW_W'($past(row) + 1'b1)));

    assert_stby_no_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
        row_drive |-> (mode_q != TB_STBY));

    assert_mode_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(mode_q));

    assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == TB_OFF && state == ST_IDLE) |=> (state == ST_IDLE));
endmodule

bind rfsh_standby_ctrl rfsh_standby_ctrl_chk #(.ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras       (ras_req),
    .cas       (cas_req),
    .row_drive (row_valid),
    .row       (row_cnt),
    .state     (state),
    .mode_q    (mode_q)
);

// File: tb/test_rfsh_standby_ctrl.sv
`timescale 1ns/1ps
module test_rfsh_standby_ctrl;
    localparam int ND = 223;
    localparam int RW = 4;
    localparam int HW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b1;
    logic slow_clk = 1'b0;
    logic cfg_wr = 1'b0;
    logic [HW+1:0] cfg_wdata = '0;
    logic ras_req, cas_req, row_valid;
    logic [RW-1:0] row_addr;

    rfsh_standby_ctrl #(.NORM_DIV(ND), .ROW_W(RW), .HOLD_W(HW)) i_rfsh_standby_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .slow_clk(slow_clk),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .ras_req(ras_req),
        .cas_req(cas_req), .row_valid(row_valid), .row_addr(row_addr)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr_cfg(input bit sb, input bit cbr, input int h);
        step(1);
        cfg_wr = 1'b1;
        cfg_wdata = {HW'(h), cbr, sb};
        step(1);
        cfg_wr = 1'b0;
    endtask

    // slow clock source
    int slow_half = 150;
    int slow_cnt = 0;
    always begin
        @(posedge clk);
        #1;
        if (slow_cnt >= slow_half - 1) begin
            slow_clk = ~slow_clk;
            slow_cnt = 0;
        end else begin
            slow_cnt++;
        end
    end

    // behavioural reference model: 0 idle, 1 cas lead, 2 both, 3 ras tail, 4 ras-only
    int m_sb = 0, m_cbr = 0, m_h = 0;
    int m_mode = 0, m_cnt = 0, m_pend = 0;
    int m_s1 = 0, m_s2 = 0, m_s3 = 0;
    int m_st = 0, m_hc = 0, m_hold = 0, m_row = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sb = 0; m_cbr = 0; m_h = 0; m_mode = 0; m_cnt = 0; m_pend = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_st = 0; m_hc = 0; m_hold = 0; m_row = 0;
        end else begin
            int mnow, tick, start, cbr_now, in_hold, hold_end;
            int n_cnt, n_pend, n_mode, n_hold, n_hc, n_row, n_st;
            mnow     = pwr_good ? 1 : (m_sb != 0 ? 2 : 0);
            tick     = ((m_mode == 1 && m_cnt == ND - 1) || (m_mode == 2 && m_s2 == 1 && m_s3 == 0)) ? 1 : 0;
            start    = (m_st == 0 && m_pend == 1 && m_mode != 0) ? 1 : 0;
            cbr_now  = (m_cbr != 0 || m_mode == 2) ? 1 : 0;
            in_hold  = (m_st == 2 || m_st == 4) ? 1 : 0;
            hold_end = (in_hold == 1 && m_hc == m_hold) ? 1 : 0;
            n_cnt  = (m_mode != 1 || m_cnt == ND - 1) ? 0 : m_cnt + 1;
            n_pend = (m_mode == 0) ? 0 : (tick == 1 ? 1 : (start == 1 ? 0 : m_pend));
            n_mode = (m_st == 0) ? mnow : m_mode;
            n_hold = (start == 1) ? m_h : m_hold;
            n_hc   = (in_hold == 1 && hold_end == 0) ? m_hc + 1 : 0;
            n_row  = (m_st == 4 && hold_end == 1) ? (m_row + 1) % (1 << RW) : m_row;
            case (m_st)
                0: n_st = (start == 1) ? (cbr_now == 1 ? 1 : 4) : 0;
                1: n_st = 2;
                2: n_st = (hold_end == 1) ? 3 : 2;
                3: n_st = 0;
                default: n_st = (hold_end == 1) ? 0 : 4;
            endcase
            if (cfg_wr) begin
                m_sb = int'(cfg_wdata[0]);
                m_cbr = int'(cfg_wdata[1]);
                m_h = int'(cfg_wdata[HW+1:2]);
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(slow_clk);
            m_cnt = n_cnt; m_pend = n_pend; m_mode = n_mode; m_hold = n_hold;
            m_hc = n_hc; m_row = n_row; m_st = n_st;
        end
    end

    // monitor state
    bit cmp_en = 0, iv_en = 0, w_en = 0, seq_en = 0, cas_en = 0, gap_en = 0;
    int iv_exp = 0, w_exp = 0, cas_exp = 0;
    string iv_tag = "R1", w_tag = "R8";
    int cyc = 0, last_st = -1, last_row = -1, wraps = 0;
    int rv_len = 0, cas_len = 0, ras_fall = -1;
    int st_cnt = 0, rv_rises = 0, cas_rises = 0;
    logic p_ras = 0, p_cas = 0, p_rv = 0;

    always @(negedge clk) begin
        if (cmp_en) begin
            logic e_ras, e_cas, e_rv;
            logic [RW-1:0] e_row;
            e_ras = (m_st == 2 || m_st == 3 || m_st == 4);
            e_cas = (m_st == 1 || m_st == 2);
            e_rv  = (m_st == 4);
            e_row = e_rv ? RW'(m_row) : '0;
            chk(ras_req == e_ras, "R7 R11 ras_req vs model", int'(ras_req), int'(e_ras));
            chk(cas_req == e_cas, "R7 R11 cas_req vs model", int'(cas_req), int'(e_cas));
            chk(row_valid == e_rv, "R8 R10 row_valid vs model", int'(row_valid), int'(e_rv));
            chk(row_addr == e_row, "R9 row_addr vs model", int'(row_addr), int'(e_row));

            if ((ras_req || cas_req) && !(p_ras || p_cas)) begin
                st_cnt++;
                if (iv_en) begin
                    if (last_st >= 0) chk(cyc - last_st == iv_exp, iv_tag, cyc - last_st, iv_exp);
                    last_st = cyc;
                end
            end
            if (row_valid) rv_len++;
            if (row_valid && !p_rv) begin
                rv_rises++;
                if (seq_en && last_row >= 0) begin
                    chk(int'(row_addr) == (last_row + 1) % (1 << RW), "R9 row step",
                        int'(row_addr), (last_row + 1) % (1 << RW));
                    if (row_addr == 0) wraps++;
                end
                last_row = int'(row_addr);
            end
            if (!row_valid && p_rv) begin
                if (w_en) chk(rv_len == w_exp, w_tag, rv_len, w_exp);
                rv_len = 0;
            end
            if (cas_req) cas_len++;
            if (cas_req && !p_cas) begin
                cas_rises++;
                if (gap_en && ras_fall >= 0) chk(cyc - ras_fall == 1, "R11 idle gap", cyc - ras_fall, 1);
            end
            if (ras_req && !p_ras && cas_req) chk(p_cas == 1'b1, "R7 cas lead", int'(p_cas), 1);
            if (!cas_req && p_cas) begin
                if (cas_en) chk(cas_len == cas_exp, "R2 R7 cas width", cas_len, cas_exp);
                chk(ras_req == 1'b1, "R7 ras after cas", int'(ras_req), 1);
                cas_len = 0;
            end
            if (!ras_req && p_ras) ras_fall = cyc;
        end
        p_ras = ras_req; p_cas = cas_req; p_rv = row_valid;
        cyc++;
    end

    initial begin
        #(4 * 40000);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        step(4);
        chk(ras_req == 0 && cas_req == 0, "R12 reset strobes", int'({ras_req, cas_req}), 0);
        chk(row_valid == 0 && row_addr == 0, "R12 reset row", int'(row_addr), 0);
        rst_n = 1'b1;
        cmp_en = 1;

        // normal mode, RAS-only, hold field 2 -> 3 clocks
        wr_cfg(1, 0, 2);
        w_en = 1; w_exp = 3; w_tag = "R2 R8 row_valid width";
        seq_en = 1;
        step(500);
        iv_en = 1; iv_exp = ND; iv_tag = "R1 normal interval"; last_st = -1;
        step(ND * 19);
        chk(wraps >= 1, "R9 wrap seen", wraps, 1);
        iv_en = 0;

        // R10: power-good drop during RAS-only sequence
        w_en = 0;
        wr_cfg(1, 0, 7);
        step(300);
        while (row_valid) step(1);
        w_exp = 8; w_tag = "R10 full sequence on drop"; w_en = 1;
        do @(negedge clk); while (!row_valid);
        @(posedge clk);
        #1;
        pwr_good = 1'b0;
        step(20);
        w_en = 0; seq_en = 0;

        // standby, CBR forced, hold 7 -> cas 9 clocks
        rv_rises = 0; cas_rises = 0;
        cas_en = 1; cas_exp = 9;
        step(400);
        iv_en = 1; iv_exp = 2 * slow_half; iv_tag = "R3 standby interval"; last_st = -1;
        step(1500);
        iv_en = 0;
        chk(rv_rises == 0, "R6 no row in standby", rv_rises, 0);
        chk(cas_rises >= 5, "R6 cbr in standby", cas_rises, 5);

        // normal CBR, hold 1 -> cas 3 clocks
        cas_en = 0;
        pwr_good = 1'b1;
        wr_cfg(1, 1, 1);
        step(300);
        cas_exp = 3; cas_en = 1;
        rv_rises = 0; cas_rises = 0;
        iv_en = 1; iv_exp = ND; iv_tag = "R1 R5 cbr interval"; last_st = -1;
        step(1500);
        iv_en = 0;
        chk(rv_rises == 0, "R5 no row in cbr", rv_rises, 0);
        chk(cas_rises >= 5, "R5 cbr seen", cas_rises, 5);

        // off: power-good low, standby not permitted
        cas_en = 0;
        wr_cfg(0, 1, 1);
        pwr_good = 1'b0;
        step(30);
        st_cnt = 0;
        step(1500);
        chk(st_cnt == 0, "R4 no refresh when off", st_cnt, 0);
        chk(ras_req == 0 && cas_req == 0, "R4 strobes low", int'({ras_req, cas_req}), 0);

        // back-to-back requests in standby
        slow_half = 3;
        wr_cfg(1, 0, 7);
        step(100);
        cas_rises = 0;
        gap_en = 1;
        step(800);
        gap_en = 0;
        chk(cas_rises >= 40, "R11 back-to-back count", cas_rises, 40);

        finish_run();
    end
endmodule